// File: doc/BRIEF.md
# Three-Backplane LCD Drive Sequencer

This block turns a vector of stored segment states into the level codes that drive a liquid-crystal panel with three common electrodes (backplanes). Each segment electrode (line) is shared by three cells, one cell on each backplane. The block steps through a frame of six equal phases. In the first three phases, each backplane in turn is made the most positive electrode. In the last three phases the same backplanes are taken in the same order but with the polarity reversed, so every cell sees zero average DC over a frame.

Every electrode is driven with a 2-bit code that selects one of four supply levels. A separate analog stage turns these codes into voltages. The two intermediate levels sit at one third and two thirds of the span between the top and bottom rails.

A shutdown input stops the phase timebase and parks every electrode at the top level. When shutdown is released, the next frame starts from its first phase.

Top module: `lcd_triplex_drive`

## Requirements
- R1: While reset is held, and on the first cycles after reset, the block is in phase 1. In phase 1, backplane 0 is at code 00 (top) and backplanes 1 and 2 are at code 10 (lower).
- R2: The phase advances once every TICK_DIV clock cycles, counted from reset release. The order is P1, P2, P3, N1, N2, N3, and after N3 the sequence returns to P1.
- R3: In positive phase Pn, backplane n-1 is at 00 and the other two backplanes are at 10.
- R4: In negative phase Nn, backplane n-1 is at 11 (bottom) and the other two backplanes are at 01 (upper).
- R5: In a positive phase, a segment line is at 11 if the cell it forms with the active backplane is on, and at 01 if that cell is off.
- R6: In a negative phase, a segment line is at 00 if its cell on the active backplane is on, and at 10 if that cell is off.
- R7: Line L occupies seg_lvl[2L+1:2L]. The cell that line L forms with backplane b is seg_state[3L+b]. Line L = 3*digit + k, where k selects the group {b, c, right annunciator}, the group {a, g, d} or the group {f, e, left annunciator}, with the segments of each group on backplanes 0, 1 and 2 in that order.
- R8: While shutdown is high, every backplane and segment output is 00. A clock edge that samples shutdown high returns the timebase to the start of P1. Counting for the next phase starts on the first edge after shutdown goes low.
- R9: Outside shutdown, exactly one backplane is at an extreme level (00 or 11) in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| shutdown | input | 1 | Stops the timebase and forces all outputs to level 00 |
| seg_state | input | NUM_DIGITS*9 | Cell on/off states; bit 3L+b is line L on backplane b |
| bp_lvl | output | 6 | Backplane level codes; bits [2b+1:2b] drive backplane b |
| seg_lvl | output | NUM_DIGITS*6 | Segment line level codes; bits [2L+1:2L] drive line L |

## Verification
The bench first applies every one of the eight on/off combinations to each line's three cells, with a different combination on neighbouring lines. Each combination is held for a full frame, so that every combination is seen against every phase. This pattern separates errors in phase polarity from errors in the choice of active backplane.

A walking single set bit across the whole state vector then checks that each cell reaches only its own line and only during the phases of its own backplane. This exposes any swap of line or backplane index.

Shutdown is asserted in the middle of a frame and then released. This checks that the outputs are parked, that the sequence restarts at phase P1, and that a cell changed in the middle of a phase appears on its line immediately.

// File: rtl/lcd_triplex_pkg.sv
package lcd_triplex_pkg;

  // Level codes sent to the analog stage, from most positive to least.
  typedef enum logic [1:0] {
    LVL_TOP    = 2'b00,
    LVL_UPPER  = 2'b01,
    LVL_LOWER  = 2'b10,
    LVL_BOTTOM = 2'b11
  } drive_lvl_t;

  localparam int unsigned BP_COUNT        = 3;
  localparam int unsigned LINES_PER_DIGIT = 3;
  localparam int unsigned CELLS_PER_DIGIT = BP_COUNT * LINES_PER_DIGIT;
  localparam int unsigned LVL_W           = 2;

endpackage

// File: rtl/lcd_reset_sync.sv
module lcd_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  // Assertion of reset is immediate; release is delayed by STAGES clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/lcd_phase_timer.sv
module lcd_phase_timer
  import lcd_triplex_pkg::*;
#(
  parameter int unsigned TICK_DIV = 1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shutdown,
  output logic [BP_COUNT-1:0] bp_sel,
  output logic                invert
);

  localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(TICK_DIV - 1);
  localparam logic [BP_COUNT-1:0] SEL_FIRST = BP_COUNT'(1);

  logic [CW-1:0]       div_q, div_d;
  logic [BP_COUNT-1:0] sel_q, sel_d;
  logic                inv_q, inv_d;
  logic                tick;

  assign tick = (div_q == DIV_LAST);

  always_comb begin
    div_d = div_q;
    sel_d = sel_q;
    inv_d = inv_q;
    if (shutdown) begin
      div_d = '0;
      sel_d = SEL_FIRST;
      inv_d = 1'b0;
    end else if (tick) begin
      div_d = '0;
      sel_d = {sel_q[BP_COUNT-2:0], sel_q[BP_COUNT-1]};
      // After the last backplane, the next frame half starts with the opposite polarity.
      if (sel_q[BP_COUNT-1]) inv_d = ~inv_q;
    end else begin
      div_d = div_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      sel_q <= SEL_FIRST;
      inv_q <= 1'b0;
    end else begin
      div_q <= div_d;
      sel_q <= sel_d;
      inv_q <= inv_d;
    end
  end

  assign bp_sel = sel_q;
  assign invert = inv_q;

endmodule

// File: rtl/lcd_bp_driver.sv
module lcd_bp_driver
  import lcd_triplex_pkg::*;
(
  input  logic                      shutdown,
  input  logic [BP_COUNT-1:0]       bp_sel,
  input  logic                      invert,
  output logic [BP_COUNT*LVL_W-1:0] bp_lvl
);

  for (genvar b = 0; b < BP_COUNT; b++) begin : g_bp
    drive_lvl_t lvl;
    always_comb begin
      if (shutdown)       lvl = LVL_TOP;
      else if (bp_sel[b]) lvl = invert ? LVL_BOTTOM : LVL_TOP;
      else                lvl = invert ? LVL_UPPER  : LVL_LOWER;
    end
    assign bp_lvl[b*LVL_W +: LVL_W] = lvl;
  end

endmodule

// File: rtl/lcd_seg_line.sv
module lcd_seg_line
  import lcd_triplex_pkg::*;
(
  input  logic                shutdown,
  input  logic [BP_COUNT-1:0] bp_sel,
  input  logic                invert,
  input  logic [BP_COUNT-1:0] cells,
  output logic [LVL_W-1:0]    lvl
);

  logic       cell_on;
  drive_lvl_t lvl_e;

  // Pick the cell that this line forms with the currently active backplane.
  assign cell_on = |(cells & bp_sel);

  always_comb begin
    if (shutdown)    lvl_e = LVL_TOP;
    else if (invert) lvl_e = cell_on ? LVL_TOP    : LVL_LOWER;
    else             lvl_e = cell_on ? LVL_BOTTOM : LVL_UPPER;
  end

  assign lvl = lvl_e;

endmodule

// File: rtl/lcd_triplex_drive.sv
module lcd_triplex_drive
  import lcd_triplex_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 8,
  parameter int unsigned TICK_DIV   = 1000
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 shutdown,
  input  logic [NUM_DIGITS*CELLS_PER_DIGIT-1:0] seg_state,
  output logic [BP_COUNT*LVL_W-1:0]            bp_lvl,
  output logic [NUM_DIGITS*LINES_PER_DIGIT*LVL_W-1:0] seg_lvl
);

  localparam int unsigned NUM_LINES = NUM_DIGITS * LINES_PER_DIGIT;

  logic                rst_sync_n;
  logic [BP_COUNT-1:0] bp_sel;
  logic                invert;

  lcd_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lcd_phase_timer #(.TICK_DIV(TICK_DIV)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .shutdown (shutdown),
    .bp_sel   (bp_sel),
    .invert   (invert)
  );

  lcd_bp_driver u_bp (
    .shutdown (shutdown),
    .bp_sel   (bp_sel),
    .invert   (invert),
    .bp_lvl   (bp_lvl)
  );

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    lcd_seg_line u_line (
      .shutdown (shutdown),
      .bp_sel   (bp_sel),
      .invert   (invert),
      .cells    (seg_state[l*BP_COUNT +: BP_COUNT]),
      .lvl      (seg_lvl[l*LVL_W +: LVL_W])
    );
  end

endmodule

// File: rtl/lcd_triplex_checker.sv
module lcd_triplex_checker
  import lcd_triplex_pkg::*;
#(
  parameter int unsigned NUM_LINES = 24,
  parameter int unsigned TICK_DIV  = 1000
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             shutdown,
  input logic [BP_COUNT*LVL_W-1:0]        bp_lvl,
  input logic [NUM_LINES*LVL_W-1:0]       seg_lvl
);

  localparam int unsigned CNTW = $clog2(TICK_DIV + 2) + 1;
  localparam logic [CNTW-1:0] CNT_LAST = CNTW'(TICK_DIV - 1);
  localparam logic [CNTW-1:0] CNT_SAT  = CNTW'(TICK_DIV);

  function automatic logic [BP_COUNT*LVL_W-1:0] first_phase_bp();
    logic [BP_COUNT*LVL_W-1:0] v;
    for (int b = 0; b < BP_COUNT; b++) v[b*LVL_W +: LVL_W] = (b == 0) ? 2'b00 : 2'b10;
    return v;
  endfunction

  logic       pos_half;
  int unsigned n_extreme, n_lower, n_upper;
  logic [NUM_LINES-1:0] seg_b0;

  always_comb begin
    pos_half  = 1'b0;
    n_extreme = 0;
    n_lower   = 0;
    n_upper   = 0;
    for (int b = 0; b < BP_COUNT; b++) begin
      logic [1:0] v;
      v = bp_lvl[b*LVL_W +: LVL_W];
      if (v == 2'b00) pos_half = 1'b1;
      if (v == 2'b00 || v == 2'b11) n_extreme++;
      if (v == 2'b10) n_lower++;
      if (v == 2'b01) n_upper++;
    end
    for (int l = 0; l < NUM_LINES; l++) seg_b0[l] = seg_lvl[l*LVL_W];
  end

  // Cycles since the backplane pattern last changed (window counter for R2).
  logic [CNTW-1:0]           cnt_q;
  logic [BP_COUNT*LVL_W-1:0] prev_bp_q;
  logic                      prev_sd_q;
  logic                      bp_changed;

  assign bp_changed = (bp_lvl != prev_bp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '1;
      prev_bp_q <= first_phase_bp();
      prev_sd_q <= 1'b0;
    end else begin
      prev_bp_q <= bp_lvl;
      prev_sd_q <= shutdown;
      if (shutdown)             cnt_q <= '1;
      else if (bp_changed)      cnt_q <= '0;
      else if (cnt_q != CNT_SAT) cnt_q <= cnt_q + CNTW'(1);
    end
  end

  assert_phase_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_changed && !prev_sd_q && !shutdown) |-> (cnt_q == CNT_LAST));

  assert_pos_idle_bp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!shutdown && pos_half) |-> (n_lower == BP_COUNT - 1));

  assert_neg_idle_bp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!shutdown && !pos_half) |-> (n_upper == BP_COUNT - 1));

  // Covers R6 too: bit 0 of every segment code follows the half of the frame.
  assert_seg_polarity_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !shutdown |-> (seg_b0 == {NUM_LINES{pos_half}}));

  assert_shutdown_park_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> (bp_lvl == '0 && seg_lvl == '0));

  assert_one_extreme_bp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !shutdown |-> (n_extreme == 1));

endmodule

bind lcd_triplex_drive lcd_triplex_checker #(
  .NUM_LINES (NUM_DIGITS * 3),
  .TICK_DIV  (TICK_DIV)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .shutdown (shutdown),
  .bp_lvl   (bp_lvl),
  .seg_lvl  (seg_lvl)
);

// File: tb/sim_lcd_triplex_drive.sv
module sim_lcd_triplex_drive;

  localparam int ND   = 2;
  localparam int DIV  = 3;
  localparam int NL   = ND * 3;
  localparam int SW   = ND * 9;

  logic          clk;
  logic          rst_n;
  logic          shutdown;
  logic [SW-1:0] seg_state;
  logic [5:0]    bp_lvl;
  logic [NL*2-1:0] seg_lvl;

  int checks;
  int errors;
  int k;
  int hold;
  bit done;

  lcd_triplex_drive #(.NUM_DIGITS(ND), .TICK_DIV(DIV)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .shutdown  (shutdown),
    .seg_state (seg_state),
    .bp_lvl    (bp_lvl),
    .seg_lvl   (seg_lvl)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [5:0] exp_bp(int ph);
    logic [5:0] v;
    for (int b = 0; b < 3; b++) begin
      if (ph < 3) v[b*2 +: 2] = (b == ph)     ? 2'b00 : 2'b10;
      else        v[b*2 +: 2] = (b == ph - 3) ? 2'b11 : 2'b01;
    end
    return v;
  endfunction

  function automatic logic [NL*2-1:0] exp_seg(int ph, logic [SW-1:0] st);
    logic [NL*2-1:0] v;
    for (int l = 0; l < NL; l++) begin
      logic on;
      on = st[l*3 + (ph % 3)];
      if (ph < 3) v[l*2 +: 2] = on ? 2'b11 : 2'b01;
      else        v[l*2 +: 2] = on ? 2'b00 : 2'b10;
    end
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (k=%0d)", tag, act, exp, k);
    end
  endtask

  task automatic check_all(input string extra);
    int ph;
    logic [5:0] ebp;
    logic [NL*2-1:0] eseg;
    int nx;
    ph = (k / DIV) % 6;
    if (shutdown) begin
      check(bp_lvl == '0, {"R8 bp ", extra}, 64'(bp_lvl), 64'd0);
      check(seg_lvl == '0, {"R8 seg ", extra}, 64'(seg_lvl), 64'd0);
    end else begin
      ebp  = exp_bp(ph);
      eseg = exp_seg(ph, seg_state);
      check(bp_lvl == ebp, {(ph < 3) ? "R2 R3 bp " : "R2 R4 bp ", extra},
            64'(bp_lvl), 64'(ebp));
      check(seg_lvl == eseg, {(ph < 3) ? "R5 R7 seg " : "R6 R7 seg ", extra},
            64'(seg_lvl), 64'(eseg));
      nx = 0;
      for (int b = 0; b < 3; b++)
        if (bp_lvl[b*2 +: 2] == 2'b00 || bp_lvl[b*2 +: 2] == 2'b11) nx++;
      check(nx == 1, {"R9 extremes ", extra}, 64'(nx), 64'd1);
    end
  endtask

  task automatic step(input string extra);
    @(posedge clk);
    if (hold > 0)      hold--;
    else if (shutdown) k = 0;
    else               k++;
    @(negedge clk);
    check_all(extra);
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; shutdown = 1'b0; seg_state = '0; k = 0; hold = 2;
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    step("R1 after release");

    // All eight cell combinations per line, shifted between neighbouring lines.
    for (int v = 0; v < 8; v++) begin
      for (int l = 0; l < NL; l++) seg_state[l*3 +: 3] = 3'((v + l) & 7);
      repeat (6 * DIV) step("combo sweep");
    end

    // Walking single cell: R7 mapping.
    for (int i = 0; i < SW; i++) begin
      seg_state = '0;
      seg_state[i] = 1'b1;
      repeat (6 * DIV) step("R7 walking cell");
    end

    // Shutdown in mid-frame, then restart at P1.
    seg_state = 18'h2A5C3;
    repeat (DIV * 4 + 1) step("pre-shutdown");
    shutdown = 1'b1;
    repeat (5) step("R8 parked");
    shutdown = 1'b0;
    repeat (12 * DIV) step("R8 restart");

    // Cell changes in the middle of a phase appear at once.
    for (int j = 0; j < 10; j++) begin
      seg_state = SW'(18'h15A3C ^ (j * 18'h0B71D));
      step("R5 R6 mid-phase change");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule